// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the interrupt status bits of a USB host controller built along open host controller lines. The controller core sends it five kinds of event: a system fault not related to the bus, resume signalling from a downstream device, the start of a frame, the completion of a done-queue pointer writeback and an overrun of the periodic schedule. Each event sets a sticky flag. Software reads the flags over a small register bus and clears each one by writing a 1 to its bit.

Some flags also feed back to the core. A pending fault flag raises a halt output that stops all further processing. A pending done-queue flag removes the permission for another writeback. A two-bit counter counts schedule overruns. An interrupt request is raised whenever an enabled flag is pending. Resume flags come only from a rising edge on the device-resume level, and no flag is set while the host drives resume itself.

Top module: `usb_host_int_status`

## Requirements
- R1: After rst_n is released, all five flags are 0, the overrun counter is 0, halt_core is 0, wb_permit is 1 and irq is 0.
- R2: With reg_addr = 0, reg_rdata shows the flags: bit 4 is the system fault, bit 3 is resume detected, bit 2 is frame start, bit 1 is done-queue written and bit 0 is schedule overrun, and the upper bits are 0. With reg_addr = 1, bits 1:0 show the overrun counter and the upper bits are 0.
- R3: A cycle with reg_wr = 1 and reg_addr = 0 clears each flag whose reg_wdata bit is 1 at the next edge. Zero bits leave their flags unchanged. A write with reg_addr = 1 changes nothing.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The resume flag is set only in a cycle where dev_resume is 1 and was 0 in the previous cycle. A steady high level does not set the flag again after it has been cleared.
- R6: The resume flag is not set by a dev_resume rising edge that occurs while host_resume is 1.
- R7: A pulse on ev_frame_start sets bit 2. A pulse on ev_sched_overrun sets bit 0.
- R8: A pulse on ev_done_written sets bit 1. wb_permit is 0 exactly while bit 1 is set.
- R9: A pulse on ev_sys_fault sets bit 4. halt_core is 1 exactly while bit 4 is set.
- R10: Each ev_sched_overrun pulse adds 1 to the overrun counter. The counter wraps from 3 to 0.
- R11: sw_reset clears all flags and the counter at the next edge. It takes priority over any event in the same cycle.
- R12: irq equals the OR of (flags AND irq_enable). Bit i of irq_enable goes with flag bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Controller software reset, synchronous |
| ev_sys_fault | input | 1 | Pulse: non-bus system fault detected |
| dev_resume | input | 1 | Level: a downstream device signals resume |
| host_resume | input | 1 | Level: the host is driving resume |
| ev_frame_start | input | 1 | Pulse: frame started and frame number updated |
| ev_done_written | input | 1 | Pulse: done-queue pointer written to memory |
| ev_sched_overrun | input | 1 | Pulse: periodic schedule ran past the frame boundary |
| irq_enable | input | 5 | Per-flag interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the flags, 1 selects the counter |
| reg_wdata | input | 8 | Write data; 1 bits clear flags |
| reg_rdata | output | 8 | Read data for reg_addr |
| halt_core | output | 1 | Stops core processing while a fault is pending |
| wb_permit | output | 1 | Core may write back the done-queue pointer |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the resume edge cases. A rising edge that arrives while host_resume is high must leave no trace, even after host_resume falls with the device level still high. A flag cleared under a steady high level must stay clear. The stimulus builds both cases with directed sequences that hold levels across several cycles. Other directed cycles line up a clearing write with an event on the same bit, and a software reset with an overrun pulse. A long random phase then mixes all inputs while a behavioural model is compared with every output on every cycle.

// File: rtl/usbhis_pkg.sv
package usbhis_pkg;
    localparam int NFLAG   = 5;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 2;

    // Bit positions that software decodes
    localparam int BIT_FAULT  = 4;
    localparam int BIT_RESUME = 3;
    localparam int BIT_FRAME  = 2;
    localparam int BIT_DONE   = 1;
    localparam int BIT_OVR    = 0;

    localparam logic ADDR_FLAGS = 1'b0;
    localparam logic ADDR_COUNT = 1'b1;
endpackage

// File: rtl/usbhis_flag_cell.sv
module usbhis_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_rst)
            st_d.flag = 1'b0;
        else if (set_i)
            st_d.flag = 1'b1;     // an event beats a clearing write
        else if (clr_i)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/usbhis_edge.sv
module usbhis_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic block_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = lvl_i && !st_q.prev && !block_i;
endmodule

// File: rtl/usbhis_counter.sv
module usbhis_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_rst)
            st_d.cnt = '0;
        else if (inc_i)
            st_d.cnt = st_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/usb_host_int_status.sv
module usb_host_int_status
    import usbhis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              ev_sys_fault,
    input  logic              dev_resume,
    input  logic              host_resume,
    input  logic              ev_frame_start,
    input  logic              ev_done_written,
    input  logic              ev_sched_overrun,
    input  logic [NFLAG-1:0]  irq_enable,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              halt_core,
    output logic              wb_permit,
    output logic              irq
);
    logic             resume_rise;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] stat_q;
    logic [CNT_W-1:0] ovr_cnt;

    usbhis_edge u_resume_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (dev_resume),
        .block_i (host_resume),
        .rise_o  (resume_rise)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[BIT_FAULT]  = ev_sys_fault;
        set_vec[BIT_RESUME] = resume_rise;
        set_vec[BIT_FRAME]  = ev_frame_start;
        set_vec[BIT_DONE]   = ev_done_written;
        set_vec[BIT_OVR]    = ev_sched_overrun;
        clr_vec = (reg_wr && reg_addr == ADDR_FLAGS) ? reg_wdata[NFLAG-1:0] : '0;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        usbhis_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_reset),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (stat_q[i])
        );
    end

    usbhis_counter #(.W(CNT_W)) u_ovr_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_reset),
        .inc_i  (ev_sched_overrun),
        .cnt_o  (ovr_cnt)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_COUNT)
            reg_rdata[CNT_W-1:0] = ovr_cnt;
        else
            reg_rdata[NFLAG-1:0] = stat_q;
    end

    assign halt_core = stat_q[BIT_FAULT];
    assign wb_permit = !stat_q[BIT_DONE];
    assign irq       = |(stat_q & irq_enable);
endmodule

// File: rtl/usb_host_int_status_chk.sv
module usb_host_int_status_chk
    import usbhis_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sw_reset,
    input logic              ev_sys_fault,
    input logic              dev_resume,
    input logic              host_resume,
    input logic              ev_frame_start,
    input logic              ev_done_written,
    input logic              ev_sched_overrun,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              halt_core,
    input logic              wb_permit,
    input logic [NFLAG-1:0]  stat_q,
    input logic [CNT_W-1:0]  ovr_cnt
);
    p_frame_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_start && !sw_reset) |=> stat_q[BIT_FRAME]);

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_start && !sw_reset && reg_wr && reg_addr == ADDR_FLAGS && reg_wdata[BIT_FRAME])
        |=> stat_q[BIT_FRAME]);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_FLAGS && reg_wdata[BIT_FRAME] && !ev_frame_start)
        |=> !stat_q[BIT_FRAME]);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !sw_reset && !ev_sys_fault && !dev_resume && !ev_frame_start
         && !ev_done_written && !ev_sched_overrun) |=> $stable(stat_q));

    p_swrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (stat_q == '0 && ovr_cnt == '0));

    p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sched_overrun && !sw_reset) |=> ovr_cnt == CNT_W'($past(ovr_cnt) + 1'b1));

    p_permit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done_written && !sw_reset) |=> !wb_permit);

    p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sys_fault && !sw_reset) |=> halt_core);

    p_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_resume && !stat_q[BIT_RESUME]) |=> !stat_q[BIT_RESUME]);
endmodule

bind usb_host_int_status usb_host_int_status_chk u_chk (.*);

// File: tb/usb_host_int_status_test.sv
`timescale 1ns/1ps
module usb_host_int_status_test;
    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       ev_sys_fault = 1'b0;
    logic       dev_resume = 1'b0;
    logic       host_resume = 1'b0;
    logic       ev_frame_start = 1'b0;
    logic       ev_done_written = 1'b0;
    logic       ev_sched_overrun = 1'b0;
    logic [4:0] irq_enable = 5'h00;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       halt_core, wb_permit, irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    logic [4:0] m_flags = 5'h00;
    int         m_cnt = 0;
    logic       m_prev = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    usb_host_int_status uut (.*);

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int exp_rd;
        exp_rd = (reg_addr == 1'b1) ? m_cnt : int'(m_flags);
        chk(tag, "rdata", int'(reg_rdata), exp_rd);
        chk(tag, "halt", int'(halt_core), int'(m_flags[4]));
        chk(tag, "permit", int'(wb_permit), int'(!m_flags[1]));
        chk(tag, "irq", int'(irq), int'(|(m_flags & irq_enable)));
    endtask

    task automatic step(string tag);
        logic [4:0] setv, clrv;
        logic       rise;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_flags = '0; m_cnt = 0; m_prev = 0;
        end else begin
            rise = dev_resume && !m_prev && !host_resume;
            m_prev = dev_resume;
            setv = {ev_sys_fault, rise, ev_frame_start, ev_done_written, ev_sched_overrun};
            clrv = (reg_wr && reg_addr == 1'b0) ? reg_wdata[4:0] : 5'h00;
            if (sw_reset) begin
                m_flags = '0; m_cnt = 0;
            end else begin
                m_flags = (m_flags & ~clrv) | setv;
                if (ev_sched_overrun) m_cnt = (m_cnt + 1) % 4;
            end
        end
        compare(tag);
        ev_sys_fault = 0; ev_frame_start = 0; ev_done_written = 0;
        ev_sched_overrun = 0; reg_wr = 0; sw_reset = 0;
    endtask

    task automatic wr(logic a, logic [7:0] d, string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step(tag);
        reg_addr = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        irq_enable = 5'h1F;
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");
        chk("R1", "permit", int'(wb_permit), 1);
        chk("R1", "rdata", int'(reg_rdata), 0);

        // R7 frame and overrun set
        ev_frame_start = 1; step("R7");
        chk("R7", "frame bit", int'(reg_rdata[2]), 1);
        ev_sched_overrun = 1; step("R7");
        chk("R7", "ovr bit", int'(reg_rdata[0]), 1);
        // R2 counter read
        reg_addr = 1; step("R2");
        chk("R2", "counter", int'(reg_rdata), 1);
        reg_addr = 0;

        // R3 clear, zero write, counter-address write
        wr(0, 8'h04, "R3");
        chk("R3", "frame cleared", int'(reg_rdata), 5'h01);
        wr(0, 8'h00, "R3");
        wr(1, 8'hFF, "R3");
        chk("R3", "ignored write", int'(reg_rdata), 5'h01);

        // R4 set wins
        ev_frame_start = 1; wr(0, 8'h04, "R4");
        chk("R4", "set wins", int'(reg_rdata[2]), 1);
        wr(0, 8'h1F, "R3");

        // R5 edge only
        dev_resume = 1; step("R5");
        chk("R5", "resume set", int'(reg_rdata[3]), 1);
        wr(0, 8'h08, "R5");
        step("R5"); step("R5");
        chk("R5", "steady level", int'(reg_rdata[3]), 0);
        dev_resume = 0; step("R5");

        // R6 host resume suppression
        host_resume = 1; dev_resume = 1; step("R6"); step("R6");
        host_resume = 0; step("R6"); step("R6");
        chk("R6", "suppressed", int'(reg_rdata[3]), 0);
        dev_resume = 0; step("R6");

        // R8 done-queue permit
        ev_done_written = 1; step("R8");
        chk("R8", "permit low", int'(wb_permit), 0);
        wr(0, 8'h02, "R8");
        chk("R8", "permit back", int'(wb_permit), 1);

        // R9 halt
        ev_sys_fault = 1; step("R9");
        chk("R9", "halt", int'(halt_core), 1);
        wr(0, 8'h10, "R9");
        chk("R9", "halt off", int'(halt_core), 0);

        // R10 wrap
        for (int i = 0; i < 4; i++) begin ev_sched_overrun = 1; step("R10"); end
        reg_addr = 1; step("R10");
        chk("R10", "wrap", int'(reg_rdata), 1);
        reg_addr = 0;

        // R11 sw reset beats events
        ev_frame_start = 1; step("R11");
        sw_reset = 1; ev_sched_overrun = 1; ev_sys_fault = 1; step("R11");
        chk("R11", "flags", int'(reg_rdata), 0);
        reg_addr = 1; step("R11");
        chk("R11", "count", int'(reg_rdata), 0);
        reg_addr = 0;

        // R12 enable masking
        ev_done_written = 1; ev_frame_start = 1; irq_enable = 5'h11; step("R12");
        chk("R12", "masked", int'(irq), 0);
        irq_enable = 5'h04; step("R12");
        chk("R12", "enabled", int'(irq), 1);
        wr(0, 8'h1F, "R12");

        // random mix, model compared every cycle
        for (int n = 0; n < 3000; n++) begin
            ev_sys_fault     = ($urandom % 40) == 0;
            ev_frame_start   = ($urandom % 6) == 0;
            ev_done_written  = ($urandom % 8) == 0;
            ev_sched_overrun = ($urandom % 7) == 0;
            sw_reset         = ($urandom % 150) == 0;
            if (($urandom % 5) == 0) dev_resume = ~dev_resume;
            if (($urandom % 20) == 0) host_resume = ~host_resume;
            irq_enable = 5'($urandom);
            reg_addr   = 1'($urandom);
            reg_wr     = ($urandom % 3) == 0;
            reg_wdata  = 8'($urandom);
            step("RAND");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule